// File: doc/BRIEF.md
# Quadword Pair Store Splitter

This block turns one 16-byte store of an even/odd register pair into two 64-bit write beats on a single write channel with a valid/ready handshake. For each request it takes the value of the even register, the value of the odd register, a base value, a flag that forces the base to zero, a 14-bit scaled displacement, the pair index and an endian-mode bit. It forms the effective address (EA) once. It then issues the beat for EA, followed by the beat for EA+8.

The endian-mode bit decides which register lands at which address and whether its bytes are reversed. In big-endian mode both registers keep their byte order. In little-endian mode the registers swap places and each one is byte-reversed.

A request is taken only while the block is idle. The block stays busy until the second beat has completed its handshake. A request whose pair index is odd issues no beats and is flagged for one cycle.

Top module: `qpair_store_split`

## Requirements
- R1: EA = base + sign-extended {disp, 2'b00}, in 64-bit arithmetic that wraps modulo 2^64. The displacement bit 13 is the sign bit.
- R2: When base_zero_i is 1, the base value is replaced by zero in the EA sum.
- R3: With le_mode_i = 0, the beat at EA carries the even register unchanged and the beat at EA+8 carries the odd register unchanged.
- R4: With le_mode_i = 1, the beat at EA carries the odd register byte-reversed and the beat at EA+8 carries the even register byte-reversed. Byte-reversal maps bits [8k+7:8k] to bits [63-8k:56-8k].
- R5: The EA beat is always issued first. The second beat's address is the first beat's address plus 8, wrapping modulo 2^64.
- R6: While wr_valid_o is high and wr_ready_i is low, wr_valid_o stays high and wr_addr_o and wr_data_o stay unchanged in the next cycle.
- R7: An accepted request raises busy_o and wr_valid_o from the cycle after acceptance. Both drop in the cycle after the second handshake. Requests presented while busy_o is high are ignored: they change no beat and raise no flag.
- R8: A request taken while idle with pair_idx_i bit 0 set drives bad_pair_o high for exactly the following cycle. It issues no beat and leaves busy_o low.
- R9: After reset, wr_valid_o, busy_o and bad_pair_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| pair_idx_i | input | 5 | Register pair index, must be even |
| even_val_i | input | 64 | Even register value |
| odd_val_i | input | 64 | Odd register value |
| base_i | input | 64 | Base value |
| base_zero_i | input | 1 | Use zero instead of base |
| disp_i | input | 14 | Signed displacement in 4-byte units |
| le_mode_i | input | 1 | 1 = little-endian placement |
| busy_o | output | 1 | A request is in flight |
| bad_pair_o | output | 1 | One-cycle flag for an odd pair index |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_addr_o | output | 64 | Write beat byte address |
| wr_data_o | output | 64 | Write beat data |

## Verification
The assertions assume that the write channel consumer obeys the handshake: it may hold wr_ready_i low for any length of time, and a beat completes only in a cycle where wr_valid_o and wr_ready_i are both high. They also assume the request inputs carry known values whenever req_valid_i is high.

The bench follows these assumptions:
- It drives all inputs at the falling edge.
- It stalls wr_ready_i randomly, with a cap on the number of stall cycles.
- It sends junk requests, some with odd indices, only while the block is busy. This exercises the ignore rule without leaving the legal input space.

// File: rtl/qss_pkg.sv
package qss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } qss_state_e;
endpackage

// File: rtl/qss_ea_calc.sv
module qss_ea_calc #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 14
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic              base_zero_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [XLEN-1:0]   ea_o
);
  localparam int OFF_W = DISP_W + 2;

  logic [OFF_W-1:0] off_scaled;
  logic [XLEN-1:0]  off_ext;
  logic [XLEN-1:0]  base_eff;

  always_comb begin
    off_scaled = {disp_i, 2'b00};
    off_ext    = {{(XLEN-OFF_W){off_scaled[OFF_W-1]}}, off_scaled};
    base_eff   = base_zero_i ? '0 : base_i;
    ea_o       = base_eff + off_ext;
  end
endmodule

// File: rtl/qss_byte_rev.sv
module qss_byte_rev #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] q_o
);
  localparam int NBYTES = XLEN / 8;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign q_o[8*k +: 8] = d_i[8*(NBYTES-1-k) +: 8];
  end
endmodule

// File: rtl/qss_beat_pair.sv
module qss_beat_pair #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] even_i,
  input  logic [XLEN-1:0] odd_i,
  input  logic            le_i,
  output logic [XLEN-1:0] lo_o,
  output logic [XLEN-1:0] hi_o
);
  logic [XLEN-1:0] even_rev;
  logic [XLEN-1:0] odd_rev;

  qss_byte_rev #(.XLEN(XLEN)) u_rev_even (.d_i(even_i), .q_o(even_rev));
  qss_byte_rev #(.XLEN(XLEN)) u_rev_odd  (.d_i(odd_i),  .q_o(odd_rev));

  always_comb begin
    if (le_i) begin
      lo_o = odd_rev;
      hi_o = even_rev;
    end else begin
      lo_o = even_i;
      hi_o = odd_i;
    end
  end
endmodule

// File: rtl/qpair_store_split.sv
module qpair_store_split #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 14,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [IDX_W-1:0]  pair_idx_i,
  input  logic [XLEN-1:0]   even_val_i,
  input  logic [XLEN-1:0]   odd_val_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic              base_zero_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              le_mode_i,
  output logic              busy_o,
  output logic              bad_pair_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [XLEN-1:0]   wr_addr_o,
  output logic [XLEN-1:0]   wr_data_o
);
  import qss_pkg::*;

  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [XLEN-1:0] ea_w, lo_w, hi_w;

  qss_ea_calc #(.XLEN(XLEN), .DISP_W(DISP_W)) u_ea (
    .base_i      (base_i),
    .base_zero_i (base_zero_i),
    .disp_i      (disp_i),
    .ea_o        (ea_w)
  );

  qss_beat_pair #(.XLEN(XLEN)) u_pair (
    .even_i (even_val_i),
    .odd_i  (odd_val_i),
    .le_i   (le_mode_i),
    .lo_o   (lo_w),
    .hi_o   (hi_w)
  );

  qss_state_e      state_q, state_d;
  logic [XLEN-1:0] ea_q, lo_q, hi_q;
  logic            bad_q, bad_d;
  logic            take, load_en, hs;

  always_comb begin
    take    = req_valid_i && (state_q == ST_IDLE);
    load_en = take && !pair_idx_i[0];
    bad_d   = take && pair_idx_i[0];
    hs      = wr_valid_o && wr_ready_i;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_en) state_d = ST_LOW;
      ST_LOW:  if (hs)      state_d = ST_HIGH;
      ST_HIGH: if (hs)      state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bad_q   <= bad_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      ea_q <= ea_w;
      lo_q <= lo_w;
      hi_q <= hi_w;
    end
  end

  always_comb begin
    busy_o     = (state_q != ST_IDLE);
    wr_valid_o = busy_o;
    bad_pair_o = bad_q;
    wr_addr_o  = (state_q == ST_HIGH) ? ea_q + STEP : ea_q;
    wr_data_o  = (state_q == ST_HIGH) ? hi_q : lo_q;
  end

  // R6: a stalled beat holds
  p_hold_beat_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  // R5: the second beat sits 8 bytes above the first
  p_second_addr_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_LOW && wr_ready_i) |=>
      (wr_valid_o && wr_addr_o == $past(wr_addr_o) + STEP));

  // R8: an odd index gives a flag and no beat
  p_odd_flag_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid_i && !busy_o && pair_idx_i[0]) |=>
      (bad_pair_o && !busy_o && !wr_valid_o));

  // R7: the last handshake ends the request
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_HIGH && wr_ready_i) |=> !wr_valid_o);

  // R7: an even request taken while idle starts a beat
  p_start_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid_i && !busy_o && !pair_idx_i[0]) |=>
      (busy_o && wr_valid_o && !bad_pair_o));
endmodule

// File: tb/qpair_store_split_bench.sv
`timescale 1ns/1ps
module qpair_store_split_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [4:0]  pair_idx;
  logic [63:0] even_v, odd_v, base_v;
  logic        base_z;
  logic [13:0] disp;
  logic        le;
  logic        busy, bad, wr_valid, wr_ready;
  logic [63:0] wr_addr, wr_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  qpair_store_split u_qpair_store_split (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .pair_idx_i(pair_idx),
    .even_val_i(even_v), .odd_val_i(odd_v), .base_i(base_v),
    .base_zero_i(base_z), .disp_i(disp), .le_mode_i(le),
    .busy_o(busy), .bad_pair_o(bad), .wr_valid_o(wr_valid),
    .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rev64(input logic [63:0] d);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = d[8*(7-k) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] calc_ea(input logic [63:0] b, input logic z,
                                          input logic [13:0] d);
    logic [63:0] off;
    off = {{48{d[13]}}, d, 2'b00};
    return (z ? 64'd0 : b) + off;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // one beat: checks each cycle while stalled (R6), then completes the handshake
  task automatic beat(input logic [63:0] ea_exp, input logic [63:0] d_exp,
                      input string atag, input string dtag, input bit junk);
    bit got = 0;
    int waits = 0;
    while (!got) begin
      chk(wr_valid == 1'b1, "R6 valid held", 64'(wr_valid), 64'd1);
      chk(wr_addr == ea_exp, atag, wr_addr, ea_exp);
      chk(wr_data == d_exp, dtag, wr_data, d_exp);
      chk(bad == 1'b0, "R7 no flag while busy", 64'(bad), 64'd0);
      if (junk) begin
        req_valid = 1'b1;
        pair_idx  = 5'($urandom());
        even_v    = rnd64();
        odd_v     = rnd64();
        base_v    = rnd64();
      end
      wr_ready = (($urandom() % 3) != 0) || (waits > 4);
      got = wr_ready;
      waits++;
      @(negedge clk);
    end
  endtask

  task automatic run_req(input logic [4:0] idx, input logic [63:0] ev,
                         input logic [63:0] od, input logic [63:0] b,
                         input logic z, input logic [13:0] d, input logic l,
                         input bit junk);
    logic [63:0] ea, lo, hi;
    string atag, dtag;
    ea   = calc_ea(b, z, d);
    lo   = l ? rev64(od) : ev;
    hi   = l ? rev64(ev) : od;
    atag = z ? "R2 addr" : "R1 addr";
    dtag = l ? "R4 data" : "R3 data";
    chk(busy == 1'b0, "R7 idle before request", 64'(busy), 64'd0);
    pair_idx = idx; even_v = ev; odd_v = od; base_v = b;
    base_z = z; disp = d; le = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (idx[0]) begin
      chk(bad == 1'b1, "R8 flag raised", 64'(bad), 64'd1);
      chk(busy == 1'b0, "R8 stays idle", 64'(busy), 64'd0);
      chk(wr_valid == 1'b0, "R8 no beat", 64'(wr_valid), 64'd0);
      @(negedge clk);
      chk(bad == 1'b0, "R8 flag one cycle", 64'(bad), 64'd0);
      chk(wr_valid == 1'b0, "R8 no later beat", 64'(wr_valid), 64'd0);
      return;
    end
    chk(busy == 1'b1, "R7 busy after accept", 64'(busy), 64'd1);
    beat(ea, lo, atag, dtag, junk);
    req_valid = 1'b0;
    beat(ea + 64'd8, hi, "R5 second addr", dtag, 1'b0);
    wr_ready = 1'b0;
    chk(wr_valid == 1'b0, "R7 valid drops after last beat", 64'(wr_valid), 64'd0);
    chk(busy == 1'b0, "R7 busy drops after last beat", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog act=%0d exp=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; wr_ready = 1'b0; pair_idx = '0;
    even_v = '0; odd_v = '0; base_v = '0; base_z = 1'b0; disp = '0; le = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_valid == 1'b0, "R9 reset valid", 64'(wr_valid), 64'd0);
    chk(busy == 1'b0, "R9 reset busy", 64'(busy), 64'd0);
    chk(bad == 1'b0, "R9 reset flag", 64'(bad), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corner cases
    run_req(5'd2, 64'h0011223344556677, 64'h8899AABBCCDDEEFF,
            64'h1000, 1'b0, 14'd5, 1'b0, 1'b0);                // R3
    run_req(5'd4, 64'h0011223344556677, 64'h8899AABBCCDDEEFF,
            64'h1000, 1'b0, 14'd5, 1'b1, 1'b0);                // R4
    run_req(5'd6, 64'hA5A5, 64'h5A5A, 64'hDEAD_BEEF_0000_0000,
            1'b1, 14'h2000, 1'b0, 1'b0);                       // R2, most negative disp
    run_req(5'd8, 64'h1, 64'h2, 64'h0, 1'b0, 14'h1FFF, 1'b1, 1'b0); // R1 largest disp
    run_req(5'd0, 64'h3, 64'h4, 64'hFFFF_FFFF_FFFF_FFF8,
            1'b0, 14'd0, 1'b0, 1'b0);                          // R5 wrap of EA+8
    run_req(5'd3, 64'h5, 64'h6, 64'h100, 1'b0, 14'd1, 1'b0, 1'b0);   // R8
    run_req(5'd31, 64'h5, 64'h6, 64'h100, 1'b0, 14'd1, 1'b1, 1'b0);  // R8
    run_req(5'd10, 64'h77, 64'h88, 64'h2000, 1'b0, 14'h3FFF, 1'b1, 1'b1); // R7 junk

    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [4:0] idx;
      idx = 5'($urandom());
      if (($urandom() % 5) != 0) idx[0] = 1'b0;
      run_req(idx, rnd64(), rnd64(), rnd64(), 1'($urandom()),
              14'($urandom()), 1'($urandom()), 1'($urandom()));
    end

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule